// File: doc/BRIEF.md
# Multi-Queue Write Port Selector

This block is the common write side of a buffer that holds 32 independent queues. A single data bus, one active-low write enable and an 8-bit address bus are shared by every queue. The caller picks a target queue by placing an address on the bus and raising the address-enable input for one clock. The selection then holds until the next one. The upper address bits name a device. This lets up to eight such blocks sit on the same bus, each strapped to its own static 3-bit identity, and only the block whose identity matches acts on the selection.

The port is built to carry a word on every clock, including the clocks around a queue change. To make that possible, a change of queue is pipelined. The old queue goes on taking words for two more edges. The full flag moves to the new queue one edge after the selection, and the new queue takes its first word on the second edge after the selection. Each queue has its own write strobe and its own full input, so the queue storage stays outside this block.

Top module: `mq_wr_port`

## Requirements
- R1: After reset no queue is selected. Every write strobe is low and the full flag is low, whatever the write enable does.
- R2: The address splits into a queue field in bits 4:0 and a device field in bits 7:5. A selection takes effect only when the device field equals `dev_id`.
- R3: A selection is taken on any rising edge where `addr_en` is high, and the level of `wr_en_n` on that edge plays no part. The selected queue then stays in place until the next selection.
- R4: From the first rising edge after a selection, `full_flag` shows the full input of the newly selected queue.
- R5: A write on the selection edge, or on the edge after it, still goes to the previously selected queue.
- R6: From the second rising edge after a selection, a write with `wr_en_n` low goes to the new queue. No write happens when `wr_en_n` is high.
- R7: At most one write strobe is high in any cycle. Strobe bit i addresses queue i.
- R8: A queue whose full input is high is never strobed, and this includes a queue that is already full when it is selected.
- R9: A selection whose device field does not match leaves this block with no queue. No strobe is raised and the full flag stays low until a matching selection takes effect.
- R10: `wr_data` presents `din` unchanged in the same cycle.
- R11: Selections arrive at least 3 clocks apart. Two selections exactly 3 clocks apart are both honoured in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_id | input | 3 | Static device identity |
| addr_en | input | 1 | Address enable; high marks a selection cycle |
| wr_addr | input | 8 | Device field [7:5], queue field [4:0] |
| wr_en_n | input | 1 | Active-low write enable |
| din | input | 18 | Write data |
| q_full | input | 32 | Per-queue full status |
| q_wr_stb | output | 32 | Per-queue write strobe, one-hot or zero |
| wr_data | output | 18 | Data word to the queues |
| full_flag | output | 1 | Full status of the selected queue |

## Verification
A queue change and an ongoing write to the old queue can land in the same cycle. The flag switch to a new queue can also coincide with the last write to the old one. The bench provokes both by holding the write enable low through selections, including a selection of a queue that is already full and two selections exactly three clocks apart. A behavioural model keeps its own timeline of selection ages and a queue occupancy count. On every clock it judges the strobe vector, the flag and the data. The model's occupancy also drives the full inputs, so full blocking and queue switching are checked together.

// File: rtl/mq_wr_pkg.sv
package mq_wr_pkg;
  // minimum spacing, in clocks, between two selections on the shared bus
  localparam int unsigned MIN_SEL_GAP = 3;

  // device field compare; kept as a function so the bench can state it differently
  function automatic logic dev_hit(input logic [7:0] addr, input logic [2:0] id,
                                   input int unsigned qw);
    logic [7:0] hi;
    hi = addr >> qw;
    return hi[2:0] == id;
  endfunction
endpackage

// File: rtl/mq_sel_decode.sv
module mq_sel_decode #(
  parameter int unsigned QW   = 5,
  parameter int unsigned ID_W = 3,
  localparam int unsigned AW  = QW + ID_W
) (
  input  logic [AW-1:0]   addr,
  input  logic [ID_W-1:0] id,
  input  logic            addr_en,
  output logic            take,
  output logic            hit,
  output logic [QW-1:0]   qsel
);
  assign take = addr_en;
  assign qsel = addr[QW-1:0];
  assign hit  = addr[AW-1:QW] == id;
endmodule

// File: rtl/mq_sel_pipe.sv
module mq_sel_pipe #(
  parameter int unsigned QW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          hit,
  input  logic [QW-1:0] qsel,
  output logic          cur_v,
  output logic [QW-1:0] cur_q
);
  logic          pend_go;
  logic          pend_hit;
  logic [QW-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_go  <= 1'b0;
      pend_hit <= 1'b0;
      pend_q   <= '0;
      cur_v    <= 1'b0;
      cur_q    <= '0;
    end else begin
      pend_go <= take;
      if (take) begin
        pend_hit <= hit;
        pend_q   <= qsel;
      end
      if (pend_go) begin
        cur_v <= pend_hit;
        cur_q <= pend_q;
      end
    end
  end

  // R5: the selection edge itself leaves the active queue alone
  p_hold_old_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cur_q == $past(cur_q) && cur_v == $past(cur_v)));

  // R4 / R9: one edge later the new queue (or no queue) is active
  p_switch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ##2 (cur_v == $past(hit, 2) && (!cur_v || cur_q == $past(qsel, 2))));

  // R3: with no selection in flight the active queue persists
  p_persist_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !pend_go) |=> ($stable(cur_q) && $stable(cur_v)));
endmodule

// File: rtl/mq_wr_steer.sv
module mq_wr_steer #(
  parameter int unsigned NUM_Q = 32,
  localparam int unsigned QW   = $clog2(NUM_Q)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cur_v,
  input  logic [QW-1:0]    cur_q,
  input  logic             wr_en_n,
  input  logic [NUM_Q-1:0] q_full,
  output logic [NUM_Q-1:0] stb,
  output logic             full_flag
);
  for (genvar i = 0; i < NUM_Q; i++) begin : g_stb
    assign stb[i] = cur_v && !wr_en_n && (cur_q == QW'(i)) && !q_full[i];
  end

  assign full_flag = cur_v && q_full[cur_q];

  // R9: without a valid selection nothing is written and the flag is low
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_v |-> (stb == '0 && !full_flag));
endmodule

// File: rtl/mq_wr_port.sv
module mq_wr_port #(
  parameter int unsigned NUM_Q  = 32,
  parameter int unsigned ID_W   = 3,
  parameter int unsigned DATA_W = 18,
  localparam int unsigned QW    = $clog2(NUM_Q),
  localparam int unsigned AW    = QW + ID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   dev_id,
  input  logic              addr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] din,
  input  logic [NUM_Q-1:0]  q_full,
  output logic [NUM_Q-1:0]  q_wr_stb,
  output logic [DATA_W-1:0] wr_data,
  output logic              full_flag
);
  import mq_wr_pkg::*;

  logic          sel_take;
  logic          sel_hit;
  logic [QW-1:0] sel_q;
  logic          act_v;
  logic [QW-1:0] act_q;

  mq_sel_decode #(.QW(QW), .ID_W(ID_W)) u_dec (
    .addr(wr_addr), .id(dev_id), .addr_en(addr_en),
    .take(sel_take), .hit(sel_hit), .qsel(sel_q)
  );

  mq_sel_pipe #(.QW(QW)) u_pipe (
    .clk(clk), .rst_n(rst_n), .take(sel_take), .hit(sel_hit), .qsel(sel_q),
    .cur_v(act_v), .cur_q(act_q)
  );

  mq_wr_steer #(.NUM_Q(NUM_Q)) u_steer (
    .clk(clk), .rst_n(rst_n), .cur_v(act_v), .cur_q(act_q), .wr_en_n(wr_en_n),
    .q_full(q_full), .stb(q_wr_stb), .full_flag(full_flag)
  );

  assign wr_data = din;

  // clocks since the last selection, saturating
  logic [2:0] gap_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)        gap_cnt <= 3'(MIN_SEL_GAP);
    else if (addr_en)  gap_cnt <= 3'd1;
    else if (gap_cnt < 3'(MIN_SEL_GAP)) gap_cnt <= gap_cnt + 3'd1;
  end

  // R11: selections keep their minimum spacing
  p_sel_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    addr_en |-> gap_cnt >= 3'(MIN_SEL_GAP));

  // R7: at most one queue strobed, and only with write enable active
  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_wr_stb) && (q_wr_stb == '0 || !wr_en_n));

  // R8: a full queue never receives a strobe
  p_no_full_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (q_wr_stb & q_full) == '0);

  // R2: a foreign device field never produces a write two edges on
  p_foreign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_en && wr_addr[AW-1:QW] != dev_id) |-> ##2 (q_wr_stb == '0));
endmodule

// File: tb/mq_wr_port_test.sv
module mq_wr_port_test;
  localparam int NQ  = 32;
  localparam int CAP = 3;
  localparam logic [2:0] MY_ID = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  dev_id = MY_ID;
  logic        addr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic        wr_en_n = 1'b1;
  logic [17:0] din = '0;
  logic [NQ-1:0] q_full;
  logic [NQ-1:0] q_wr_stb;
  logic [17:0] wr_data;
  logic        full_flag;

  always #10 clk = ~clk;

  mq_wr_port uut (
    .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .addr_en(addr_en), .wr_addr(wr_addr),
    .wr_en_n(wr_en_n), .din(din), .q_full(q_full), .q_wr_stb(q_wr_stb),
    .wr_data(wr_data), .full_flag(full_flag)
  );

  // behavioural queue model
  int occ [NQ];
  always_comb for (int i = 0; i < NQ; i++) q_full[i] = (occ[i] >= CAP);

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  // selection timeline: active queue, and a pending one with its age in edges
  int m_act = -1;            // -1: nothing selected
  int m_new = -1;
  int m_age = -1;            // -1: no selection in flight

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // compare outputs for the inputs now applied, then take one edge
  task automatic step(input string tag);
    logic [NQ-1:0] e_stb;
    bit e_flag;
    #3;
    e_stb  = '0;
    e_flag = (m_act >= 0) && (occ[m_act] >= CAP);
    if (m_act >= 0 && !wr_en_n && occ[m_act] < CAP) e_stb[m_act] = 1'b1;
    chk(tag, "stb", longint'(q_wr_stb), longint'(e_stb));
    chk(tag, "flag", longint'(full_flag), longint'(e_flag));
    chk("R10", "data", longint'(wr_data), longint'(din));
    @(posedge clk);
    if (m_act >= 0 && e_stb != '0) occ[m_act]++;
    if (m_age >= 0) begin
      m_age++;
      if (m_age == 2) begin m_act = m_new; m_age = -1; end
    end
    if (rst_n && addr_en) begin
      m_new = (wr_addr[7:5] == dev_id) ? int'(wr_addr[4:0]) : -1;
      m_age = 1;
    end
    @(negedge clk);
    addr_en = 1'b0;
  endtask

  task automatic pick(input logic [2:0] id, input int q, input bit wn, input string tag);
    addr_en = 1'b1; wr_addr = {id, 5'(q)}; wr_en_n = wn; din = 18'($urandom);
    step(tag);
  endtask

  task automatic wr(input bit wn, input string tag);
    wr_en_n = wn; din = 18'($urandom);
    step(tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NQ; i++) occ[i] = 0;
    @(negedge clk); @(negedge clk);
    // R1: in reset and just after, nothing strobed
    wr_en_n = 1'b0; #3;
    chk("R1", "stb in reset", longint'(q_wr_stb), 0);
    chk("R1", "flag in reset", longint'(full_flag), 0);
    @(negedge clk); rst_n = 1'b1;
    wr(0, "R1"); wr(0, "R1");

    // R3: select q3 with write enable high; R6 writes follow
    pick(MY_ID, 3, 1, "R3");
    wr(0, "R3"); wr(0, "R6"); wr(1, "R6"); wr(0, "R6");
    // R5: change to q9 while writing every cycle
    pick(MY_ID, 9, 0, "R5");
    wr(0, "R5"); wr(0, "R6"); wr(0, "R6");
    // R8 / R4: fill q12, then select it while still writing q9
    occ[12] = CAP; occ[9] = 0;
    pick(MY_ID, 12, 0, "R4");
    wr(0, "R4"); wr(0, "R8"); wr(0, "R8");
    // R2 / R9: foreign device field, queue 12 of another device
    pick(3'd2, 12, 0, "R2");
    wr(0, "R2"); wr(0, "R9"); wr(0, "R9"); wr(1, "R9");
    // R11: two selections exactly three clocks apart
    occ[12] = 0;
    pick(MY_ID, 1, 0, "R11");
    wr(0, "R11"); wr(0, "R11");
    pick(MY_ID, 2, 0, "R11");
    wr(0, "R11"); wr(0, "R11"); wr(0, "R7");

    // mixed traffic
    for (int n = 0; n < 120; n++) begin
      int gap = 3 + int'($urandom_range(0, 3));
      logic [2:0] id = ($urandom_range(0, 5) == 0) ? 3'd1 : MY_ID;
      pick(id, int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), "R6");
      for (int k = 1; k < gap; k++) begin
        int d = int'($urandom_range(0, 7));
        if (occ[d] > 0 && $urandom_range(0, 2) == 0) occ[d]--;
        wr(1'($urandom_range(0, 3) == 0), "R7");
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule